// File: doc/BRIEF.md
# Packed Rounded Multiply-High Unit

This block is a single-cycle registered SIMD datapath for fixed-point scaling. It takes two packed vectors of signed 16-bit lanes and multiplies each lane pair to a 32-bit product. It rounds the product to nearest at bit 15 and returns the 16 bits just under the sign bit of the rounded value. For Q15 operands, that is the Q15 product rounded to nearest. The vector width is set by a parameter to 64, 128, 256 or 512 bits, and every lane is computed in parallel.

Each lane can be written under a per-lane mask. A lane whose mask bit is clear either keeps the previous destination value, which is supplied on an input, or is forced to zero. A zeroing control chooses between the two. When masking is off, every lane receives its computed value. A valid strobe goes in with the operands and comes out one cycle later with the registered result. While no valid input is presented, the result register holds its value.

Top module: `pmr_top`

## Requirements
- R1: Each lane's result is bits [16:1] of (bits [31:14] of the signed 32-bit product of the two lane operands, plus one). Equivalently, it is the low 16 bits of ((a*b >>> 14) + 1) >>> 1.
- R2: When both operands of a lane are -32768 (0x8000), the lane result is 0x8000. The result wraps and does not saturate.
- R3: Lane i occupies bits [16*i+15:16*i] of the operands, the prior value and the result. No lane's result depends on another lane's operands.
- R4: When maskEnable is 0, every lane is written with its computed value, whatever laneMask holds.
- R5: When maskEnable is 1, zeroMode is 0 and laneMask bit i is 0, result lane i takes lane i of priorDst.
- R6: When maskEnable is 1, zeroMode is 1 and laneMask bit i is 0, result lane i is 0x0000.
- R7: When maskEnable is 1 and laneMask bit i is 1, result lane i is the computed value, in both merge and zeroing modes.
- R8: outValid is 1 in the cycle after a cycle with inValid at 1, and 0 in the cycle after a cycle with inValid at 0.
- R9: While inValid is 0, result keeps its value whatever the data inputs do.
- R10: While rstN is low, outValid is 0 and result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands valid this cycle |
| srcA | input | VEC_W | First packed operand, signed 16-bit lanes |
| srcB | input | VEC_W | Second packed operand, signed 16-bit lanes |
| priorDst | input | VEC_W | Previous destination value used for merging |
| laneMask | input | VEC_W/16 | Per-lane write mask, bit i for lane i |
| maskEnable | input | 1 | 1 applies laneMask, 0 writes all lanes |
| zeroMode | input | 1 | 1 zeroes unmasked lanes, 0 merges them |
| outValid | output | 1 | Result updated from the previous cycle's inputs |
| result | output | VEC_W | Packed rounded high products |

## Verification
The assertions take for granted that reset is held for at least one clock edge before inValid is first raised. They also assume that every input is at a known level at each rising edge. The lane checks relate a load cycle to the register contents one cycle later, so they rely on the data inputs being stable across the sampling edge. The bench drives every input at the falling edge and releases reset before the first vector. Between vectors it lowers inValid and scrambles the data inputs, so the hold property is tested against inputs that really change.

// File: rtl/pmr_pkg.sv
`timescale 1ns/1ps
package pmr_pkg;
  localparam int LANE_W = 16;

  typedef struct packed {
    logic loadEn;
    logic zeroFill;
  } pmrStrobeT;

  function automatic logic [LANE_W-1:0] roundedHigh(input logic [LANE_W-1:0] a,
                                                    input logic [LANE_W-1:0] b);
    logic signed [2*LANE_W-1:0] prod;
    logic [2*LANE_W-1:0] biased;
    prod   = $signed(a) * $signed(b);
    biased = prod + 32'h0000_4000;
    return biased[30:15];
  endfunction
endpackage

// File: rtl/pmr_lane.sv
`timescale 1ns/1ps
module pmr_lane
  import pmr_pkg::*;
(
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  input  logic [LANE_W-1:0] prior,
  input  logic              keep,
  input  logic              zeroFill,
  output logic [LANE_W-1:0] laneNext
);
  logic signed [2*LANE_W-1:0] product;
  logic [2*LANE_W-1:0]        biased;
  logic [LANE_W-1:0]          scaled;
  logic                       laneUnused;

  // adding 1 at bit 14 equals adding 1 at the LSB of product[31:14]
  assign product    = $signed(opA) * $signed(opB);
  assign biased     = product + 32'h0000_4000;
  assign scaled     = biased[30:15];
  assign laneUnused = ^{biased[31], biased[14:0]};

  always_comb begin
    if (keep)          laneNext = scaled;
    else if (zeroFill) laneNext = '0;
    else               laneNext = prior;
  end

  always_comb begin
    if (opA == 16'h8000 && opB == 16'h8000)
      assert (scaled == 16'h8000); // R2
  end
endmodule

// File: rtl/pmr_ctrl.sv
`timescale 1ns/1ps
module pmr_ctrl
  import pmr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEnable,
  input  logic             zeroMode,
  output pmrStrobeT        strobe,
  output logic [LANES-1:0] laneKeep,
  output logic             outValid
);
  always_comb begin
    strobe.loadEn   = inValid;
    strobe.zeroFill = zeroMode;
    laneKeep        = maskEnable ? laneMask : {LANES{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8
  AST_KEEP_ALL: assert property (@(posedge clk) disable iff (!rstN)
    !maskEnable |-> (laneKeep == {LANES{1'b1}})); // R4
endmodule

// File: rtl/pmr_datapath.sv
`timescale 1ns/1ps
module pmr_datapath
  import pmr_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int LANES = VEC_W / LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmrStrobeT        strobe,
  input  logic [LANES-1:0] laneKeep,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] priorDst,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] nextVec;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    pmr_lane uLane (
      .opA      (srcA[i*LANE_W +: LANE_W]),
      .opB      (srcB[i*LANE_W +: LANE_W]),
      .prior    (priorDst[i*LANE_W +: LANE_W]),
      .keep     (laneKeep[i]),
      .zeroFill (strobe.zeroFill),
      .laneNext (nextVec[i*LANE_W +: LANE_W])
    );

    AST_LANE_MERGE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadEn && !laneKeep[i] && !strobe.zeroFill) |=>
      (result[i*LANE_W +: LANE_W] == $past(priorDst[i*LANE_W +: LANE_W]))); // R5
    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadEn && !laneKeep[i] && strobe.zeroFill) |=>
      (result[i*LANE_W +: LANE_W] == '0)); // R6
    AST_LANE_CALC: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadEn && laneKeep[i]) |=>
      (result[i*LANE_W +: LANE_W] ==
       roundedHigh($past(srcA[i*LANE_W +: LANE_W]), $past(srcB[i*LANE_W +: LANE_W])))); // R1
    AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadEn && laneKeep[i] && srcA[i*LANE_W +: LANE_W] == 16'h8000 &&
       srcB[i*LANE_W +: LANE_W] == 16'h8000) |=>
      (result[i*LANE_W +: LANE_W] == 16'h8000)); // R2
  end

  always_ff @(posedge clk) begin
    if (!rstN)              result <= '0;
    else if (strobe.loadEn) result <= nextVec;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(result)); // R9
endmodule

// File: rtl/pmr_top.sv
`timescale 1ns/1ps
module pmr_top
  import pmr_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int LANES = VEC_W / LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] priorDst,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEnable,
  input  logic             zeroMode,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  initial begin
    assert (VEC_W == 64 || VEC_W == 128 || VEC_W == 256 || VEC_W == 512); // R3
  end

  pmrStrobeT        strobe;
  logic [LANES-1:0] laneKeep;

  pmr_ctrl #(.LANES(LANES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .laneMask   (laneMask),
    .maskEnable (maskEnable),
    .zeroMode   (zeroMode),
    .strobe     (strobe),
    .laneKeep   (laneKeep),
    .outValid   (outValid)
  );

  pmr_datapath #(.VEC_W(VEC_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .laneKeep (laneKeep),
    .srcA     (srcA),
    .srcB     (srcB),
    .priorDst (priorDst),
    .result   (result)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0)); // R10
endmodule

// File: tb/sim_pmr_top.sv
`timescale 1ns/1ps
module sim_pmr_top;
  localparam int VEC_W = 128;
  localparam int LANES = VEC_W / 16;

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic [VEC_W-1:0] srcA, srcB, priorDst, result;
  logic [LANES-1:0] laneMask;
  logic maskEnable, zeroMode, outValid;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;
  logic [VEC_W-1:0] lastResult;

  always #2 clk = ~clk; // 250 MHz

  pmr_top #(.VEC_W(VEC_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .priorDst(priorDst), .laneMask(laneMask), .maskEnable(maskEnable),
    .zeroMode(zeroMode), .outValid(outValid), .result(result)
  );

  function automatic logic [15:0] refLane(input logic [15:0] a, input logic [15:0] b);
    longint p;
    longint r;
    p = longint'($signed(a)) * longint'($signed(b));
    r = ((p >>> 14) + 1) >>> 1;
    return r[15:0];
  endfunction

  function automatic logic [VEC_W-1:0] refVec(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                                              input logic [VEC_W-1:0] pr, input logic [LANES-1:0] m,
                                              input logic men, input logic zm);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      if (!men || m[i])  v[i*16 +: 16] = refLane(a[i*16 +: 16], b[i*16 +: 16]);
      else if (zm)       v[i*16 +: 16] = 16'h0000;
      else               v[i*16 +: 16] = pr[i*16 +: 16];
    end
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] rndVec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [VEC_W-1:0] got, input logic [VEC_W-1:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic runVec(input string req, input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                        input logic [VEC_W-1:0] pr, input logic [LANES-1:0] m,
                        input logic men, input logic zm);
    srcA = a; srcB = b; priorDst = pr; laneMask = m; maskEnable = men; zeroMode = zm;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 outValid", {{(VEC_W-1){1'b0}}, outValid}, {{(VEC_W-1){1'b0}}, 1'b1});
    check(req, result, refVec(a, b, pr, m, men, zm));
    lastResult = result;
  endtask

  task automatic holdCheck();
    srcA = rndVec(); srcB = rndVec(); priorDst = rndVec();
    laneMask = LANES'($urandom); maskEnable = 1'($urandom); zeroMode = 1'($urandom);
    @(negedge clk);
    srcA = rndVec();
    @(negedge clk);
    check("R8 outValid idle", {{(VEC_W-1){1'b0}}, outValid}, '0);
    check("R9 hold", result, lastResult);
  endtask

  function automatic logic [VEC_W-1:0] fill(input logic [15:0] w);
    return {LANES{w}};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0;
    srcA = '0; srcB = '0; priorDst = '0; laneMask = '0; maskEnable = 1'b0; zeroMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset result", result, '0);
    check("R10 reset outValid", {{(VEC_W-1){1'b0}}, outValid}, '0);
    srcA = rndVec(); srcB = rndVec(); inValid = 1'b1;
    @(negedge clk);
    check("R10 reset dominates", result, '0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runVec("R2 min*min", fill(16'h8000), fill(16'h8000), '0, '0, 1'b0, 1'b0);
    check("R2 value", result, fill(16'h8000));
    runVec("R1 zero", fill(16'h0000), rndVec(), '0, '0, 1'b0, 1'b0);
    runVec("R1 max*max", fill(16'h7FFF), fill(16'h7FFF), '0, '0, 1'b0, 1'b0);
    check("R1 max*max value", result, fill(16'h7FFE));
    runVec("R1 max*-max", fill(16'h7FFF), fill(16'h8001), '0, '0, 1'b0, 1'b0);
    runVec("R1 -max*-max", fill(16'h8001), fill(16'h8001), '0, '0, 1'b0, 1'b0);
    runVec("R1 min*max", fill(16'h8000), fill(16'h7FFF), '0, '0, 1'b0, 1'b0);
    runVec("R1 round half", fill(16'h0001), fill(16'h4000), '0, '0, 1'b0, 1'b0);
    runVec("R1 mixed sign", {4{16'h8000, 16'h1234}}, {4{16'h7FFF, 16'hF00D}}, '0, '0, 1'b0, 1'b0);
    // R3: extreme neighbours around an ordinary lane
    runVec("R3 isolation", {16'h8000, 16'h8000, 16'h0003, 16'h7FFF, 16'h8000, 16'h0100, 16'h8000, 16'h7FFF},
           {16'h8000, 16'h7FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hFF00, 16'h8000, 16'h8001}, '0, '0, 1'b0, 1'b0);
    holdCheck();
    // masking modes
    runVec("R4 mask ignored", rndVec(), rndVec(), rndVec(), 8'h00, 1'b0, 1'b1);
    runVec("R5 merge", rndVec(), rndVec(), rndVec(), 8'hA5, 1'b1, 1'b0);
    runVec("R6 zeroing", rndVec(), rndVec(), rndVec(), 8'h5A, 1'b1, 1'b1);
    runVec("R6 all zero", fill(16'h8000), fill(16'h8000), rndVec(), 8'h00, 1'b1, 1'b1);
    check("R6 all zero value", result, '0);
    runVec("R7 all set merge", rndVec(), rndVec(), rndVec(), 8'hFF, 1'b1, 1'b0);
    runVec("R7 all set zero", rndVec(), rndVec(), rndVec(), 8'hFF, 1'b1, 1'b1);
    holdCheck();

    // constrained random, biased toward extremes
    for (int n = 0; n < 300; n++) begin
      logic [VEC_W-1:0] a, b;
      a = rndVec(); b = rndVec();
      for (int i = 0; i < LANES; i++) begin
        case ($urandom % 6)
          0: a[i*16 +: 16] = 16'h8000;
          1: a[i*16 +: 16] = 16'h7FFF;
          2: b[i*16 +: 16] = 16'h8001;
          default: ;
        endcase
      end
      runVec("R1 R3 random", a, b, rndVec(), LANES'($urandom), 1'($urandom), 1'($urandom));
      if (n % 37 == 0) holdCheck();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule